// File: doc/BRIEF.md
# Slot-Framed SPI Command Bridge

This block turns a staged three-slot command word into SPI traffic. Each 16-bit slot pairs a data byte with two 4-bit framing codes. The leading code sets chip select before the byte goes out. The trailing code decides whether chip select stays asserted or is released once the byte is done. Because framing is decided per byte, one SPI frame can span several slots, several slots can each form their own frame, or a frame can remain open across two commands.

The host writes the 48-bit staging word and then pulses a start input. After that it advances the bridge with single-cycle step strobes, 24 per slot. The bridge works in SPI mode 0, MSB first, with the clock idle low. Each byte the slave returns replaces the data field of its slot, so once the command completes the same word holds the reply.

If a leading or trailing code is not recognised, the bridge releases the port and ends the command early.

Top module: `spib_bridge`

## Requirements
- R1: While reset is high, and on the first edge after it, csbm is 1, sckm is 0, mosi is 0, busy is 0, done is 0 and rd_data is all zero.
- R2: On step 1 of a slot, a leading code of 4'b1000 drives csbm to 0 and a leading code of 4'b1001 drives csbm to 1. In both cases the byte is then transferred.
- R3: On step 24 of a slot, a trailing code whose low three bits are 3'b000 drives csbm to 0, with bit 3 ignored. A trailing code of 4'b1001 drives csbm to 1. csbm keeps its last value after the command ends.
- R4: Each data bit uses two steps. Steps 3, 5, ... 17 put the next data bit on mosi (MSB first) with sckm low. Steps 4, 6, ... 18 raise sckm and sample miso. Step 19 returns sckm low.
- R5: At step 19 the captured byte replaces that slot's data field. Both codes of the slot are kept.
- R6: Any other leading code, including 4'b1111, releases the port at step 1 of its slot: csbm=1, sckm=0, mosi=0, the command ends, and later slots are neither shifted nor changed. Any other trailing code does the same at step 24.
- R7: When a command ends, busy falls and done is high for exactly one cycle. A command that runs all three slots takes exactly 72 steps.
- R8: While busy, wr_en and start are ignored. While idle, step is ignored. A start while idle raises busy on the next cycle. In cycles with no step, the SPI outputs hold their values.
- R9: wr_data and rd_data hold slot 0 in bits [47:32], slot 1 in [31:16] and slot 2 in [15:0]. Slots are run in the order 0, 1, 2. Each slot is laid out as {leading code [15:12], data [11:4], trailing code [3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load wr_data into the staging word (idle only) |
| wr_data | input | 48 | Three slots to stage |
| start | input | 1 | Begin a command (idle only) |
| step | input | 1 | One sequencing step while busy |
| miso | input | 1 | Serial data from the slave |
| csbm | output | 1 | SPI chip select, active low |
| sckm | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| rd_data | output | 48 | Staging word, with replies written back |

## Verification
A wrong phase or slot count shows at the pins within a step or two. It appears as a clock edge in the wrong place, a bit on mosi that does not match the expected byte, or a chip-select change off step 1 or step 24. The reference model compares every output on every cycle, so such a fault is reported in the cycle it first appears. A fault in decoding a framing code shows no later than the end of that slot, as a chip-select level or an early done. A fault in the writeback path shows on rd_data once step 19 of the affected slot has passed.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t LEAD_SEL   = 4'b1000;
  localparam code_t LEAD_DESEL = 4'b1001;
  localparam code_t TRAIL_DESEL = 4'b1001;

  function automatic logic lead_known(code_t c);
    return (c == LEAD_SEL) || (c == LEAD_DESEL);
  endfunction

  function automatic logic lead_selects(code_t c);
    return c == LEAD_SEL;
  endfunction

  function automatic logic trail_holds(code_t c);
    return c[2:0] == 3'b000;
  endfunction

  function automatic logic trail_known(code_t c);
    return trail_holds(c) || (c == TRAIL_DESEL);
  endfunction
endpackage

// File: rtl/spib_slot_store.sv
module spib_slot_store
  import spib_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int BYTE_W = 8,
  localparam int SLOT_W  = 2*CODE_W + BYTE_W,
  localparam int TOTAL_W = SLOTS*SLOT_W,
  localparam int SL_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TOTAL_W-1:0] load_data,
  input  logic              wb_en,
  input  logic [SL_W-1:0]   wb_slot,
  input  logic [BYTE_W-1:0] wb_byte,
  input  logic [SL_W-1:0]   rd_slot,
  output code_t             lead,
  output logic [BYTE_W-1:0] payload,
  output code_t             trail,
  output logic [TOTAL_W-1:0] flat
);
  logic [SLOT_W-1:0] mem [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          mem[g] <= '0;
        end else if (load) begin
          mem[g] <= load_data[(SLOTS-1-g)*SLOT_W +: SLOT_W];
        end else if (wb_en && (wb_slot == SL_W'(g))) begin
          mem[g][CODE_W +: BYTE_W] <= wb_byte;
        end
      end
      assign flat[(SLOTS-1-g)*SLOT_W +: SLOT_W] = mem[g];
    end
  endgenerate

  logic [SLOT_W-1:0] cur;
  assign cur     = mem[rd_slot];
  assign lead    = cur[SLOT_W-1 -: CODE_W];
  assign payload = cur[CODE_W +: BYTE_W];
  assign trail   = cur[CODE_W-1:0];
endmodule

// File: rtl/spib_sequencer.sv
module spib_sequencer #(
  parameter int SLOTS      = 3,
  parameter int BYTE_W     = 8,
  parameter int SLOT_TICKS = 24,
  localparam int PRE_TICKS = 2,
  localparam int BIT_FIRST = PRE_TICKS,
  localparam int BIT_END   = PRE_TICKS + 2*BYTE_W,
  localparam int LAST      = SLOT_TICKS - 1,
  localparam int PH_W      = $clog2(SLOT_TICKS),
  localparam int SL_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            step,
  input  logic            lead_ok,
  input  logic            trail_ok,
  output logic            busy,
  output logic            done,
  output logic [SL_W-1:0] slot,
  output logic            at_lead,
  output logic            at_drive,
  output logic            at_sample,
  output logic            at_settle,
  output logic            at_trail,
  output logic            abort
);
  localparam logic DRIVE_LSB = 1'(BIT_FIRST % 2);

  logic [PH_W-1:0] phase;
  logic tick, in_bits, ends_now;

  assign tick      = busy && step;
  assign in_bits   = (phase >= PH_W'(BIT_FIRST)) && (phase < PH_W'(BIT_END));
  assign at_lead   = tick && (phase == '0);
  assign at_drive  = tick && in_bits && (phase[0] == DRIVE_LSB);
  assign at_sample = tick && in_bits && (phase[0] != DRIVE_LSB);
  assign at_settle = tick && (phase == PH_W'(BIT_END));
  assign at_trail  = tick && (phase == PH_W'(LAST));
  assign abort     = (at_lead && !lead_ok) || (at_trail && !trail_ok);
  assign ends_now  = abort || (at_trail && (slot == SL_W'(SLOTS-1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= '0;
      slot  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= '0;
          slot  <= '0;
        end
      end else if (step) begin
        if (ends_now) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (at_trail) begin
          slot  <= slot + 1'b1;
          phase <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spib_shift_engine.sv
module spib_shift_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_lead,
  input  logic              at_drive,
  input  logic              at_sample,
  input  logic              at_settle,
  input  logic              at_trail,
  input  logic              abort,
  input  logic              lead_sel,
  input  logic              trail_desel,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              csbm,
  output logic              sckm,
  output logic              mosi
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      csbm <= 1'b1;
      sckm <= 1'b0;
      mosi <= 1'b0;
      sh   <= '0;
    end else if (abort) begin
      csbm <= 1'b1;
      sckm <= 1'b0;
      mosi <= 1'b0;
    end else begin
      if (at_lead) begin
        csbm <= !lead_sel;
        sh   <= tx_byte;
      end
      if (at_drive) begin
        mosi <= sh[BYTE_W-1];
        sckm <= 1'b0;
      end
      if (at_sample) begin
        sckm <= 1'b1;
        sh   <= {sh[BYTE_W-2:0], miso};
      end
      if (at_settle) sckm <= 1'b0;
      if (at_trail)  csbm <= trail_desel;
    end
  end

  assign rx_byte = sh;
endmodule

// File: rtl/spib_bridge.sv
module spib_bridge
  import spib_pkg::*;
#(
  parameter int SLOTS      = 3,
  parameter int BYTE_W     = 8,
  parameter int SLOT_TICKS = 24,
  localparam int SLOT_W  = 2*CODE_W + BYTE_W,
  localparam int TOTAL_W = SLOTS*SLOT_W,
  localparam int SL_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [TOTAL_W-1:0] wr_data,
  input  logic               start,
  input  logic               step,
  input  logic               miso,
  output logic               csbm,
  output logic               sckm,
  output logic               mosi,
  output logic               busy,
  output logic               done,
  output logic [TOTAL_W-1:0] rd_data
);
  code_t             lead, trail;
  logic [BYTE_W-1:0] payload, rx_byte;
  logic [SL_W-1:0]   slot;
  logic at_lead, at_drive, at_sample, at_settle, at_trail, abort;

  spib_slot_store #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) store_i (
    .clk(clk), .rst(rst),
    .load(wr_en && !busy), .load_data(wr_data),
    .wb_en(at_settle), .wb_slot(slot), .wb_byte(rx_byte),
    .rd_slot(slot), .lead(lead), .payload(payload), .trail(trail),
    .flat(rd_data)
  );

  spib_sequencer #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .SLOT_TICKS(SLOT_TICKS)) seq_i (
    .clk(clk), .rst(rst), .start(start), .step(step),
    .lead_ok(lead_known(lead)), .trail_ok(trail_known(trail)),
    .busy(busy), .done(done), .slot(slot),
    .at_lead(at_lead), .at_drive(at_drive), .at_sample(at_sample),
    .at_settle(at_settle), .at_trail(at_trail), .abort(abort)
  );

  spib_shift_engine #(.BYTE_W(BYTE_W)) eng_i (
    .clk(clk), .rst(rst),
    .at_lead(at_lead), .at_drive(at_drive), .at_sample(at_sample),
    .at_settle(at_settle), .at_trail(at_trail), .abort(abort),
    .lead_sel(lead_selects(lead)), .trail_desel(!trail_holds(trail)),
    .tx_byte(payload), .miso(miso), .rx_byte(rx_byte),
    .csbm(csbm), .sckm(sckm), .mosi(mosi)
  );
endmodule

// File: rtl/spib_bridge_chk.sv
module spib_bridge_chk #(
  parameter int TOTAL_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               start,
  input logic               step,
  input logic               csbm,
  input logic               sckm,
  input logic               mosi,
  input logic               busy,
  input logic               done,
  input logic [TOTAL_W-1:0] rd_data
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (csbm && !sckm && !mosi && !busy && !done));

  // R8
  clk_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sckm));

  // R3
  cs_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(csbm));

  // R8
  idle_mosi_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(mosi));

  // R4
  clk_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sckm |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  // R8
  idle_store_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_en) |=> $stable(rd_data));

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

bind spib_bridge spib_bridge_chk #(.TOTAL_W(TOTAL_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .start(start), .step(step),
  .csbm(csbm), .sckm(sckm), .mosi(mosi), .busy(busy), .done(done),
  .rd_data(rd_data)
);

// File: tb/spib_bridge_tb_top.sv
module spib_bridge_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [47:0] wr_data = '0;
  logic start = 1'b0;
  logic step = 1'b0;
  logic miso;
  logic csbm, sckm, mosi, busy, done;
  logic [47:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit compare_on = 1'b0;

  always #10 clk = ~clk;

  spib_bridge dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .step(step), .miso(miso), .csbm(csbm), .sckm(sckm), .mosi(mosi),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  rep [3];
  logic [47:0] m_reg;
  logic [7:0]  m_sh;
  logic m_cs, m_sck, m_mosi, m_busy, m_done;
  int ph, sl;
  logic [3:0] ic, fc;
  logic [7:0] dat;

  assign miso = (m_busy && ph >= 3 && ph <= 17 && (ph % 2) == 1)
                ? rep[sl][7 - (ph - 3) / 2] : 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= '0; m_sh <= '0; m_cs <= 1'b1; m_sck <= 1'b0; m_mosi <= 1'b0;
      m_busy <= 1'b0; m_done <= 1'b0; ph <= 0; sl <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (wr_en) m_reg <= wr_data;
        if (start) begin m_busy <= 1'b1; ph <= 0; sl <= 0; end
      end else if (step) begin
        ic  = m_reg[47 - 16*sl -: 4];
        dat = m_reg[43 - 16*sl -: 8];
        fc  = m_reg[35 - 16*sl -: 4];
        if (ph == 0) begin
          if (ic == 4'h8 || ic == 4'h9) begin
            m_cs <= (ic == 4'h9); m_sh <= dat; ph <= 1;
          end else begin
            m_cs <= 1'b1; m_sck <= 1'b0; m_mosi <= 1'b0;
            m_busy <= 1'b0; m_done <= 1'b1;
          end
        end else if (ph == 23) begin
          if (fc[2:0] == 3'b000 || fc == 4'h9) begin
            m_cs <= (fc == 4'h9);
            if (sl == 2) begin m_busy <= 1'b0; m_done <= 1'b1; end
            else begin sl <= sl + 1; ph <= 0; end
          end else begin
            m_cs <= 1'b1; m_sck <= 1'b0; m_mosi <= 1'b0;
            m_busy <= 1'b0; m_done <= 1'b1;
          end
        end else begin
          if (ph >= 2 && ph <= 17 && (ph % 2) == 0) begin
            m_mosi <= m_sh[7]; m_sck <= 1'b0;
          end
          if (ph >= 3 && ph <= 17 && (ph % 2) == 1) begin
            m_sck <= 1'b1; m_sh <= {m_sh[6:0], miso};
          end
          if (ph == 18) begin
            m_sck <= 1'b0; m_reg[43 - 16*sl -: 8] <= m_sh;
          end
          ph <= ph + 1;
        end
      end
    end
  end

  // serial capture of what the bridge sent, independent of the model
  logic [23:0] tx_cap = '0;
  always @(posedge sckm) tx_cap <= {tx_cap[22:0], mosi};

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compare_on) begin
      chk("R2/R3/R6 csbm", 48'(csbm), 48'(m_cs));
      chk("R4 sckm", 48'(sckm), 48'(m_sck));
      chk("R4 mosi", 48'(mosi), 48'(m_mosi));
      chk("R7/R8 busy", 48'(busy), 48'(m_busy));
      chk("R7 done", 48'(done), 48'(m_done));
      chk("R5/R9 rd_data", rd_data, m_reg);
    end
  end

  task automatic load(input logic [47:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input bit gap, output int n);
    n = 0;
    step = 1'b1;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (done) break;
      if (gap) begin step = 1'b0; @(negedge clk); step = 1'b1; end
    end
    step = 1'b0;
  endtask

  int n;

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 csbm", 48'(csbm), 48'd1);
    chk("R1 sckm", 48'(sckm), 48'd0);
    chk("R1 busy", 48'(busy), 48'd0);
    chk("R1 rd_data", rd_data, 48'd0);
    rst = 1'b0;
    compare_on = 1'b1;

    // S1: three separately framed bytes
    rep[0] = 8'h5A; rep[1] = 8'hC3; rep[2] = 8'h0F;
    load({16'h8A59, 16'h83C9, 16'h8F09});
    go();
    run(1'b0, n);
    chk("R7 full command steps", 48'(n), 48'd72);
    chk("R5/R9 replies written back", rd_data, {16'h85A9, 16'h8C39, 16'h80F9});
    chk("R4 bytes sent MSB first", 48'(tx_cap), 48'hA53CF0);
    chk("R3 released after 1001", 48'(csbm), 48'd1);

    // R8: step while idle ignored
    step = 1'b1; repeat (4) @(negedge clk); step = 1'b0;
    chk("R8 idle step busy", 48'(busy), 48'd0);
    chk("R8 idle step sckm", 48'(sckm), 48'd0);

    // S2: frame left open (X000 trailing codes, bit 3 ignored)
    rep[0] = 8'h01; rep[1] = 8'h02; rep[2] = 8'h03;
    load({16'h8110, 16'h8228, 16'h8330});
    go();
    run(1'b0, n);
    chk("R3 cs held low after command", 48'(csbm), 48'd0);

    // S2b: leading 1001 deselects, gapped steps
    rep[0] = 8'h9E; rep[1] = 8'h4B; rep[2] = 8'h77;
    load({16'h9449, 16'h8558, 16'h8669});
    go();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R2 lead 1001 raises cs", 48'(csbm), 48'd1);
    @(negedge clk);
    run(1'b1, n);
    chk("R7 gapped command steps", 48'(n + 1), 48'd72);
    chk("R2 byte shifted under 1001", rd_data[47:32], 48'h99E9);

    // S3: leading 1111 in slot 1 releases the port
    rep[0] = 8'hAA; rep[1] = 8'hBB; rep[2] = 8'hCC;
    load({16'h8660, 16'hF779, 16'h8889});
    go();
    run(1'b0, n);
    chk("R6 release after 25 steps", 48'(n), 48'd25);
    chk("R6 later slots untouched", rd_data, {16'h8AA0, 16'hF779, 16'h8889});
    chk("R6 cs high on release", 48'(csbm), 48'd1);
    chk("R6 last byte sent", 48'(tx_cap[7:0]), 48'h66);

    // S4: unknown leading code in slot 0
    load({16'h5129, 16'h8349, 16'h8569});
    go();
    run(1'b0, n);
    chk("R6 unknown lead ends at step 1", 48'(n), 48'd1);
    chk("R6 unknown lead no change", rd_data, {16'h5129, 16'h8349, 16'h8569});

    // S5: unknown trailing code in slot 0
    rep[0] = 8'hE1;
    load({16'h89D3, 16'h8AB9, 16'h8CD9});
    go();
    run(1'b0, n);
    chk("R6 unknown trail ends at step 24", 48'(n), 48'd24);
    chk("R5/R6 slot written before release", rd_data, {16'h8E13, 16'h8AB9, 16'h8CD9});
    chk("R6 cs high after bad trail", 48'(csbm), 48'd1);

    // S6: wr_en and start ignored while busy
    rep[0] = 8'h10; rep[1] = 8'h20; rep[2] = 8'h30;
    load({16'h8129, 16'h8349, 16'h8569});
    go();
    step = 1'b1; repeat (5) @(negedge clk); step = 1'b0;
    wr_en = 1'b1; wr_data = 48'hFFFF_FFFF_FFFF; start = 1'b1;
    @(negedge clk); wr_en = 1'b0; start = 1'b0;
    run(1'b0, n);
    chk("R8 busy ignores start", 48'(n + 5), 48'd72);
    chk("R8 busy ignores write", rd_data, {16'h8109, 16'h8209, 16'h8309});

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule